// File: doc/BRIEF.md
# Shadowed SRAM Autostore Controller

This block is a byte-wide static RAM backed, bit for bit, by a nonvolatile shadow array. The shadow array is modelled here as a second internal memory of the same shape. A host reads and writes the RAM through active-low chip-select, read-enable and write-enable inputs. The block drives its data output only while a read is enabled.

The block also moves whole-array images between the two memories. After a power-on reset it copies every shadow word into the RAM, and host access waits until that copy is done. When a digital supply-low flag is raised, it copies the RAM image into the shadow array, but only when three conditions hold:

- the RAM has been written since power-up;
- read-enable is not held low;
- the supply is still low when a short start window ends.

Once a store begins it runs to the end. The block then stays locked until the next power-on reset. A digital flag and a reset input stand in for the analog supply comparator and the real nonvolatile cells.

Top module: `nvsram_ctrl`

## Requirements
- R1: While `por` is high, `busy` is high. After `por` falls, `busy` stays high until the recall finishes. Counting the rising edges from the first one with `por` low, inclusive, `busy` is high after each of the first DEPTH+1 edges and low after edge DEPTH+2 (DEPTH = 2**ADDR_W = 2048).
- R2: A host read happens when `ce_n`=0, `oe_n`=0 and `we_n`=1 on a rising edge while not busy and `supply_low`=0. After that edge, `dq_oe`=1 and `dq_o` carries the byte stored at `addr`.
- R3: `dq_oe` is 0 and `dq_o` is all zeros after any edge where `ce_n` or `oe_n` was high.
- R4: A host write happens when `ce_n`=0 and `we_n`=0 on a rising edge while not busy and `supply_low`=0. The write stores `dq_i` at `addr`. When `oe_n` is also low, the write still happens and the output stays off.
- R5: Each power-on recall loads every RAM address with the word held at the same shadow address.
- R6: `supply_low`=1 while ready, with at least one host write since the last power-on reset and `oe_n`=1, starts a store. `busy` goes high after that edge. The store copies every RAM word into the shadow array. The block then keeps `busy` high, whatever `supply_low` does, until the next power-on reset.
- R7: With no host write since the last power-on reset, `supply_low` starts no store. `busy` stays low and the shadow array is unchanged.
- R8: With `oe_n`=0, `supply_low` starts no store. If `oe_n` falls during the start window, the store is cancelled, `busy` falls and the shadow array is unchanged.
- R9: If `supply_low` returns to 0 within the START_DLY-cycle start window, the store is cancelled. `busy` goes low after the next edge and the shadow array is unchanged.
- R10: While `supply_low`=1, host reads and writes have no effect. The data output stays off and the RAM is unchanged.
- R11: From entering the store state to reaching the locked state takes no more than STORE_BOUND cycles (default 500000, which is 2.5 ms at 200 MHz).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| supply_low | input | 1 | Supply below sense threshold |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low; low vetoes a store |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Host word address |
| dq_i | input | 8 | Host write data |
| dq_o | output | 8 | Host read data, zero when not driven |
| dq_oe | output | 1 | Output driver enable |
| busy | output | 1 | High in every state except ready |

## Verification
The store path is tried with four input patterns. A dirty RAM with read-enable high is the only one expected to copy. A clean RAM, read-enable held low, and a supply that recovers inside the start window must each leave the shadow array untouched. Each outcome is judged by a later power-on recall, which reveals the shadow contents at the ports. Host access is tried at the lowest and highest addresses, with the enable combinations that must and must not drive the bus, and again while the supply flag is raised.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
    typedef enum logic [2:0] {
        ST_POR    = 3'd0,
        ST_RECALL = 3'd1,
        ST_READY  = 3'd2,
        ST_STORE  = 3'd3,
        ST_LOCKED = 3'd4
    } nvs_state_e;
endpackage

// File: rtl/nvs_mem.sv
module nvs_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // single port, read-before-write, registered read data
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/nvs_host.sv
module nvs_host (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic supply_low,
    input  logic ready,
    output logic wr_stb,
    output logic rd_stb
);
    logic open_d;

    always_comb begin
        open_d = ready && !supply_low && !ce_n;
        wr_stb = open_d && !we_n;
        rd_stb = open_d && !oe_n && we_n;
    end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvsram_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int START_DLY   = 8,
    parameter int STORE_BOUND = 500000
) (
    input  logic              clk,
    input  logic              por,
    input  logic              supply_low,
    input  logic              oe_n,
    input  logic              host_wr,
    output logic              ready,
    output logic              ram_x_we,
    output logic [ADDR_W-1:0] ram_x_addr,
    output logic              shd_we,
    output logic [ADDR_W-1:0] shd_addr
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;
    localparam int DLYW  = (START_DLY < 1) ? 1 : $clog2(START_DLY + 1);
    localparam logic [CW-1:0]   CNT_END = CW'(DEPTH);
    localparam logic [DLYW-1:0] DLY_INI = DLYW'(START_DLY);

    typedef struct packed {
        nvs_state_e        st;
        logic [CW-1:0]     cnt;
        logic              pend;
        logic [ADDR_W-1:0] waddr;
        logic              dirty;
        logic              go;
        logic [DLYW-1:0]   dly;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_POR, cnt: '0, pend: 1'b0, waddr: '0,
                                 dirty: 1'b0, go: 1'b0, dly: '0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        ram_x_we   = 1'b0;
        shd_we     = 1'b0;
        ram_x_addr = seq_q.waddr;
        shd_addr   = seq_q.waddr;

        if (host_wr) begin
            seq_d.dirty = 1'b1;
        end

        case (seq_q.st)
            ST_POR: begin
                seq_d.st    = ST_RECALL;
                seq_d.cnt   = '0;
                seq_d.pend  = 1'b0;
                seq_d.dirty = 1'b0;
            end
            ST_RECALL: begin
                // shadow read at cnt, RAM written one cycle later
                shd_addr = seq_q.cnt[ADDR_W-1:0];
                ram_x_we = seq_q.pend;
                if (seq_q.cnt != CNT_END) begin
                    seq_d.cnt   = seq_q.cnt + 1'b1;
                    seq_d.pend  = 1'b1;
                    seq_d.waddr = seq_q.cnt[ADDR_W-1:0];
                end else begin
                    seq_d.pend = 1'b0;
                    seq_d.st   = ST_READY;
                end
            end
            ST_READY: begin
                if (supply_low && seq_q.dirty && oe_n) begin
                    seq_d.st  = ST_STORE;
                    seq_d.go  = 1'b0;
                    seq_d.dly = DLY_INI;
                end
            end
            ST_STORE: begin
                if (!seq_q.go) begin
                    if (!oe_n || !supply_low) begin
                        seq_d.st = ST_READY;
                    end else if (seq_q.dly == '0) begin
                        seq_d.go   = 1'b1;
                        seq_d.cnt  = '0;
                        seq_d.pend = 1'b0;
                    end else begin
                        seq_d.dly = seq_q.dly - 1'b1;
                    end
                end else begin
                    // RAM read at cnt, shadow written one cycle later
                    ram_x_addr = seq_q.cnt[ADDR_W-1:0];
                    shd_we     = seq_q.pend;
                    if (seq_q.cnt != CNT_END) begin
                        seq_d.cnt   = seq_q.cnt + 1'b1;
                        seq_d.pend  = 1'b1;
                        seq_d.waddr = seq_q.cnt[ADDR_W-1:0];
                    end else begin
                        seq_d.pend  = 1'b0;
                        seq_d.go    = 1'b0;
                        seq_d.dirty = 1'b0;
                        seq_d.st    = ST_LOCKED;
                    end
                end
            end
            ST_LOCKED: begin
                seq_d.st = ST_LOCKED;
            end
            default: begin
                seq_d = SEQ_RST;
            end
        endcase

        ready = (seq_q.st == ST_READY);
    end

    always_ff @(posedge clk) begin
        if (por) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    // store duration monitor
    localparam int SCW = $clog2(STORE_BOUND + 2);
    logic [SCW-1:0] stc_d, stc_q;

    always_comb begin
        stc_d = stc_q;
        if (seq_q.st != ST_STORE) begin
            stc_d = '0;
        end else if (stc_q != SCW'(STORE_BOUND + 1)) begin
            stc_d = stc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            stc_q <= '0;
        end else begin
            stc_q <= stc_d;
        end
    end

    a_r11_store_bounded: assert property (@(posedge clk) disable iff (por)
        stc_q <= SCW'(STORE_BOUND));

    a_r1_recall_follows_por: assert property (@(posedge clk) disable iff (por)
        $fell(por) |=> seq_q.st == ST_RECALL);

    a_r6_store_needs_dirty: assert property (@(posedge clk) disable iff (por)
        (seq_q.st == ST_STORE && $past(seq_q.st) == ST_READY) |-> $past(seq_q.dirty && oe_n));

    a_r8_veto_cancels: assert property (@(posedge clk) disable iff (por)
        (seq_q.st == ST_STORE && !seq_q.go && !oe_n) |=> seq_q.st == ST_READY);

    a_r6_locked_holds: assert property (@(posedge clk) disable iff (por)
        seq_q.st == ST_LOCKED |=> seq_q.st == ST_LOCKED);
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int START_DLY   = 8,
    parameter int STORE_BOUND = 500000
) (
    input  logic              clk,
    input  logic              por,
    input  logic              supply_low,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              busy
);
    logic              ready, wr_stb, rd_stb;
    logic              ram_x_we, shd_we;
    logic [ADDR_W-1:0] ram_x_addr, shd_addr;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata, shd_rdata;
    logic              oe_d, oe_q;

    nvs_host u_host (
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .supply_low (supply_low),
        .ready      (ready),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb)
    );

    nvs_seq #(
        .ADDR_W      (ADDR_W),
        .START_DLY   (START_DLY),
        .STORE_BOUND (STORE_BOUND)
    ) u_seq (
        .clk        (clk),
        .por        (por),
        .supply_low (supply_low),
        .oe_n       (oe_n),
        .host_wr    (wr_stb),
        .ready      (ready),
        .ram_x_we   (ram_x_we),
        .ram_x_addr (ram_x_addr),
        .shd_we     (shd_we),
        .shd_addr   (shd_addr)
    );

    always_comb begin
        ram_we    = wr_stb || ram_x_we;
        ram_addr  = ready ? addr : ram_x_addr;
        ram_wdata = ready ? dq_i : shd_rdata;
        oe_d      = rd_stb;
    end

    nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
        .clk   (clk),
        .we    (shd_we),
        .addr  (shd_addr),
        .wdata (ram_rdata),
        .rdata (shd_rdata)
    );

    always_ff @(posedge clk) begin
        if (por) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= oe_d;
        end
    end

    assign dq_oe = oe_q;
    assign dq_o  = oe_q ? ram_rdata : '0;
    assign busy  = !ready;

    a_r3_bus_quiet: assert property (@(posedge clk) disable iff (por)
        dq_oe |-> $past(!ce_n && !oe_n));

    a_r10_inhibit_reads: assert property (@(posedge clk) disable iff (por)
        supply_low |=> !dq_oe);

    a_r4_no_xfer_during_host: assert property (@(posedge clk) disable iff (por)
        wr_stb |-> !ram_x_we && !shd_we);
endmodule

// File: tb/nvsram_ctrl_tb.sv
`timescale 1ns/1ps
module nvsram_ctrl_tb;
    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SDLY  = 8;

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          supply_low = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .START_DLY(SDLY)) u_dut (
        .clk(clk), .por(por), .supply_low(supply_low), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 7 + 3);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hwrite(input int a, input logic [DW-1:0] d, input logic oe_low);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = !oe_low; addr = AW'(a); dq_i = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic hread(input int a, input logic c_n, input logic o_n,
                         output logic oe_s, output logic [DW-1:0] d_s);
        @(negedge clk);
        ce_n = c_n; oe_n = o_n; we_n = 1'b1; addr = AW'(a);
        @(negedge clk);
        oe_s = dq_oe; d_s = dq_o;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // power-on reset then count edges until ready
    task automatic power_up(input string req, input bit do_check);
        int n;
        @(negedge clk);
        por = 1'b1;
        repeat (3) @(negedge clk);
        if (do_check) check(req, "busy during por", busy, 1);
        por = 1'b0;
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (busy && n < DEPTH + 20);
        if (do_check) check(req, "edges until ready", n, DEPTH + 2);
    endtask

    task automatic sweep(input string req, input string what);
        int errs = 0;
        logic o; logic [DW-1:0] d;
        for (int a = 0; a < DEPTH; a++) begin
            hread(a, 1'b0, 1'b0, o, d);
            if (!o || d != pat(a)) errs++;
        end
        check(req, what, errs, 0);
    endtask

    task automatic t_reset;
        power_up("R1", 1'b1);
        check("R3", "dq_oe idle after reset", dq_oe, 0);
    endtask

    task automatic t_host_rw;
        logic o; logic [DW-1:0] d;
        hwrite(0, 8'hA5, 1'b0);
        hwrite(DEPTH - 1, 8'h3C, 1'b0);
        hread(0, 1'b0, 1'b0, o, d);
        check("R2", "read addr 0 oe", o, 1);
        check("R2", "read addr 0 data", d, 8'hA5);
        hread(DEPTH - 1, 1'b0, 1'b0, o, d);
        check("R4", "read top addr data", d, 8'h3C);
        hread(0, 1'b0, 1'b1, o, d);
        check("R3", "oe_n high dq_oe", o, 0);
        check("R3", "oe_n high dq_o", d, 0);
        hread(0, 1'b1, 1'b0, o, d);
        check("R3", "ce_n high dq_oe", o, 0);
        // write with oe_n low also: write wins, no drive
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = AW'(7); dq_i = 8'h5E;
        @(negedge clk);
        check("R4", "no drive during write", dq_oe, 0);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        hread(7, 1'b0, 1'b0, o, d);
        check("R4", "write with oe low stored", d, 8'h5E);
    endtask

    task automatic t_store;
        for (int a = 0; a < DEPTH; a++) hwrite(a, pat(a), 1'b0);
        @(negedge clk);
        supply_low = 1'b1;
        @(negedge clk);
        check("R6", "busy after supply low", busy, 1);
        repeat (SDLY + DEPTH + 20) @(negedge clk);
        supply_low = 1'b0;
        repeat (20) @(negedge clk);
        check("R6", "locked after store", busy, 1);
        power_up("R5", 1'b1);
        sweep("R11", "store completed, full image recalled"); // R5 R6 R11
    endtask

    task automatic t_clean;
        logic o; logic [DW-1:0] d;
        power_up("R7", 1'b0);
        @(negedge clk);
        supply_low = 1'b1;
        repeat (SDLY + 20) @(negedge clk);
        check("R7", "clean ram no store busy", busy, 0);
        hread(3, 1'b0, 1'b0, o, d);
        check("R10", "read inhibited", o, 0);
        hwrite(3, 8'hEE, 1'b0);
        @(negedge clk);
        supply_low = 1'b0;
        hread(3, 1'b0, 1'b0, o, d);
        check("R10", "write inhibited", d, pat(3));
        power_up("R7", 1'b0);
        hread(3, 1'b0, 1'b0, o, d);
        check("R7", "shadow kept", d, pat(3));
    endtask

    task automatic t_veto;
        logic o; logic [DW-1:0] d;
        hwrite(5, 8'h99, 1'b0);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        supply_low = 1'b1;
        repeat (SDLY + 20) @(negedge clk);
        check("R8", "oe low vetoes store", busy, 0);
        supply_low = 1'b0; oe_n = 1'b1;
        // veto during start window
        @(negedge clk);
        supply_low = 1'b1;
        repeat (2) @(negedge clk);
        check("R8", "window entered", busy, 1);
        oe_n = 1'b0;
        @(negedge clk);
        check("R8", "oe low cancels window", busy, 0);
        oe_n = 1'b1; supply_low = 1'b0;
        // recovery during start window
        @(negedge clk);
        supply_low = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "window entered", busy, 1);
        supply_low = 1'b0;
        @(negedge clk);
        check("R9", "recovery cancels store", busy, 0);
        repeat (SDLY + 10) @(negedge clk);
        check("R9", "stays ready", busy, 0);
        hread(5, 1'b0, 1'b0, o, d);
        check("R4", "new byte in ram", d, 8'h99);
        power_up("R9", 1'b0);
        hread(5, 1'b0, 1'b0, o, d);
        check("R9", "shadow unchanged", d, pat(5));
    endtask

    initial begin
        t_reset();
        t_host_rw();
        t_store();
        t_clean();
        t_veto();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule